// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request source and an asynchronous static RAM that is four bits wide and 256 words deep. It takes one word per request on a valid/ready handshake and drives the memory's address, write data, two chip selects (one active low, one active high), active-low write strobe and active-low output enable. It returns read data with a single-cycle valid pulse.

Every nanosecond timing rule of the memory is a parameter. The clock period is a parameter too. Each phase length is the ceiling of its nanosecond figure divided by the period, and never less than one cycle. A write runs through address and select setup, a write pulse of minimum width, and a hold phase that keeps address, data and selects steady after the strobe rises. The hold phase is stretched if needed so that the whole write meets the minimum write cycle time. A read keeps the selects and the output enable active for the access time and samples the memory outputs on the last edge of that window.

The controller has six states. IDLE accepts requests. SETUP, PULSE and HOLD form a write. ACCESS and CAPTURE form a read. The transitions are:
- IDLE→SETUP on an accepted write.
- IDLE→ACCESS on an accepted read.
- SETUP→PULSE, PULSE→HOLD, HOLD→IDLE and ACCESS→CAPTURE, each when the phase counter expires.
- CAPTURE→IDLE unconditionally.

Top module: `asram_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1 and `rsp_valid`=0.
- R2: `req_ready` is 1 only in IDLE. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. A write keeps `req_ready` low for SETUP+PULSE+HOLD cycles (4 with the defaults). A read keeps it low for ACCESS+1 cycles (3 with the defaults). In IDLE the memory is deselected.
- R3: In a write, the selects (`mem_sel_n`=0, `mem_sel`=1), address and data are driven for SETUP_CYC cycles before `mem_we_n` falls (1 with the defaults: setup 0 ns at a 5 ns clock).
- R4: `mem_we_n` is low for exactly PULSE_CYC consecutive cycles, and only while selected. PULSE_CYC = ceil(max(pulse width, data setup)/period), which is 2 with the defaults (8 ns).
- R5: After `mem_we_n` rises, selects, address and data stay driven for HOLD_CYC cycles, then the memory is deselected. HOLD_CYC is the larger of ceil(largest hold/period) and write-cycle cycles minus SETUP_CYC minus PULSE_CYC (1 with the defaults).
- R6: `mem_addr` and `mem_wdata` hold the accepted request's values for every cycle the memory is selected, even if the request inputs change.
- R7: `mem_oe_n` stays high throughout a write. `mem_we_n` and `mem_oe_n` are never low together.
- R8: In a read, the memory is selected with `mem_oe_n`=0 and `mem_we_n`=1 for ACC_CYC cycles, where ACC_CYC = ceil(max(address access, output-enable access)/period) (2 with the defaults). `mem_rdata` is sampled on the edge that ends this window.
- R9: One cycle after the read window, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` carries the sampled word. A write produces no `rsp_valid`.
- R10: A read returns the last word written to that address (checked at addresses 0x00 and 0xFF and after an overwrite).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 8 | Memory address pins |
| mem_wdata | output | 4 | Memory data input pins |
| mem_rdata | input | 4 | Memory data output pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
A wrong state shows at once on the memory pins. A phase counter that is off by one changes how many cycles the write strobe or the output enable stays low, and the bench counts those cycles from the first edge after the request is taken. A read that samples too early picks up the complemented word, which the memory model drives until the access window has run. The error then shows in `rsp_rdata` on the cycle of the response pulse. A stuck or skipped state shows as a wrong number of busy cycles on `req_ready`, or as a missing or doubled response pulse.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_ACCESS,
        ST_CAPTURE
    } seq_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (cap_en) begin
            dout <= din;
        end
    end

    AST_CAP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(dout)); // R9

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 4,
    parameter int CLK_PERIOD_NS   = 5,
    parameter int T_WCYCLE_NS     = 10,
    parameter int T_WPULSE_NS     = 8,
    parameter int T_ADDR_SETUP_NS = 0,
    parameter int T_ADDR_HOLD_NS  = 2,
    parameter int T_DATA_SETUP_NS = 0,
    parameter int T_DATA_HOLD_NS  = 2,
    parameter int T_SEL_SETUP_NS  = 0,
    parameter int T_SEL_HOLD_NS   = 2,
    parameter int T_ADDR_ACC_NS   = 10,
    parameter int T_OE_ACC_NS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    localparam int unsigned PER       = CLK_PERIOD_NS;
    localparam int unsigned SETUP_CYC = ns_to_cyc(max2(T_ADDR_SETUP_NS, T_SEL_SETUP_NS), PER);
    localparam int unsigned PULSE_CYC = ns_to_cyc(max2(T_WPULSE_NS, T_DATA_SETUP_NS), PER);
    localparam int unsigned HOLD_MIN  = ns_to_cyc(max2(T_ADDR_HOLD_NS,
                                                       max2(T_DATA_HOLD_NS, T_SEL_HOLD_NS)), PER);
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WCYCLE_NS, PER);
    localparam int unsigned HOLD_CYC  = (SETUP_CYC + PULSE_CYC + HOLD_MIN >= WC_CYC)
                                        ? HOLD_MIN : (WC_CYC - SETUP_CYC - PULSE_CYC);
    localparam int unsigned ACC_CYC   = ns_to_cyc(max2(T_ADDR_ACC_NS, T_OE_ACC_NS), PER);
    localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, ACC_CYC));
    localparam int          CNT_W     = $clog2(MAX_CYC + 1);

    seq_state_e state_q, state_d;

    logic              accept;
    logic              tmr_load;
    logic              tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              cap_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign accept = req_valid && req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_write ? ST_SETUP : ST_ACCESS;
            ST_SETUP:   if (tmr_done)  state_d = ST_PULSE;
            ST_PULSE:   if (tmr_done)  state_d = ST_HOLD;
            ST_HOLD:    if (tmr_done)  state_d = ST_IDLE;
            ST_ACCESS:  if (tmr_done)  state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase length loaded on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:  tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_PULSE:  tmr_val = CNT_W'(PULSE_CYC - 1);
            ST_HOLD:   tmr_val = CNT_W'(HOLD_CYC - 1);
            ST_ACCESS: tmr_val = CNT_W'(ACC_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // request fields held for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
        end
    end

    assign cap_en = (state_q == ST_ACCESS) && tmr_done;

    asram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_rdata),
        .dout   (rsp_rdata)
    );

    // outputs decoded from the state register
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_sel_n = 1'b1;
        mem_sel   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_SETUP,
            ST_HOLD:    begin mem_sel_n = 1'b0; mem_sel = 1'b1; end
            ST_PULSE:   begin mem_sel_n = 1'b0; mem_sel = 1'b1; mem_we_n = 1'b0; end
            ST_ACCESS:  begin mem_sel_n = 1'b0; mem_sel = 1'b1; mem_oe_n = 1'b0; end
            ST_CAPTURE: rsp_valid = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;

    AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n)); // R2
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_sel_n)); // R3
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel)); // R4
    AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_sel_n); // R5
    AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R6
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n || mem_oe_n)); // R7
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

endmodule

// File: tb/asram_seq_tb.sv
`timescale 1ns/100ps
module asram_seq_tb_top;

    localparam int TB_CLK_NS = 5;
    localparam int EXP_SETUP = 1;   // ceil(0/5) raised to 1
    localparam int EXP_PULSE = 2;   // ceil(8/5)
    localparam int EXP_HOLD  = 1;   // ceil(2/5); 1+2+1 >= ceil(10/5)
    localparam int EXP_ACC   = 2;   // ceil(10/5)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic       rsp_valid;
    logic [3:0] rsp_rdata;
    logic [7:0] mem_addr;
    logic [3:0] mem_wdata;
    logic [3:0] mem_rdata;
    logic       mem_sel_n, mem_sel, mem_we_n, mem_oe_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    logic [3:0] sram   [256];
    logic [3:0] expect_mem [256];
    int         oe_run = 0;

    always #(TB_CLK_NS/2.0) clk = ~clk;

    asram_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // behavioural memory: writes while strobe low, data valid only after the access window
    always @(posedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_we_n) sram[mem_addr] <= mem_wdata;
        oe_run <= (!mem_sel_n && mem_sel && !mem_oe_n) ? oe_run + 1 : 0;
    end

    assign mem_rdata = (!mem_sel_n && mem_sel && mem_we_n && !mem_oe_n && oe_run >= EXP_ACC - 1)
                       ? sram[mem_addr] : ~sram[mem_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !rsp_valid,
            "R1 pins in reset", {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, rsp_valid}, 6'b110110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_sel_n && mem_we_n && mem_oe_n && !rsp_valid,
            "R1 pins after reset", {req_ready, mem_sel_n, mem_we_n, mem_oe_n, rsp_valid}, 5'b11110);
    endtask

    task automatic t_write(input logic [7:0] a, input logic [3:0] d);
        int busy = 0, setup = 0, pulse = 0, hold = 0, we_edges = 0, oe_bad = 0, pin_bad = 0, rsp_cnt = 0;
        bit prev_we = 1'b1;
        @(negedge clk);
        chk(req_ready, "R2 ready before write", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // R6 inputs change mid-transfer
        while (!req_ready && busy < 50) begin
            busy++;
            if (!mem_sel_n && mem_sel) begin
                if (!mem_we_n) pulse++;
                else if (pulse == 0) setup++;
                else hold++;
                if (mem_addr != a || mem_wdata != d) pin_bad++;
            end
            if (!mem_we_n && prev_we) we_edges++;
            prev_we = mem_we_n;
            if (!mem_oe_n) oe_bad++;
            if (rsp_valid) rsp_cnt++;
            @(negedge clk);
        end
        expect_mem[a] = d;
        chk(busy == EXP_SETUP + EXP_PULSE + EXP_HOLD, "R2 write busy cycles", busy, EXP_SETUP + EXP_PULSE + EXP_HOLD);
        chk(setup == EXP_SETUP, "R3 setup cycles", setup, EXP_SETUP);
        chk(pulse == EXP_PULSE && we_edges == 1, "R4 strobe cycles", pulse, EXP_PULSE);
        chk(hold == EXP_HOLD, "R5 hold cycles", hold, EXP_HOLD);
        chk(mem_sel_n && !mem_sel, "R5 deselected after hold", mem_sel_n, 1);
        chk(pin_bad == 0, "R6 address/data stable", pin_bad, 0);
        chk(oe_bad == 0, "R7 oe high in write", oe_bad, 0);
        chk(rsp_cnt == 0, "R9 no response on write", rsp_cnt, 0);
    endtask

    task automatic t_read(input logic [7:0] a);
        int busy = 0, oe_cyc = 0, we_bad = 0, rsp_cnt = 0;
        logic [3:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 4'h0;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        while (!req_ready && busy < 50) begin
            busy++;
            if (!mem_sel_n && mem_sel && !mem_oe_n) begin
                oe_cyc++;
                if (mem_addr != a) we_bad++;
            end
            if (!mem_we_n) we_bad++;
            if (rsp_valid) begin rsp_cnt++; got = rsp_rdata; end
            @(negedge clk);
        end
        chk(busy == EXP_ACC + 1, "R2 read busy cycles", busy, EXP_ACC + 1);
        chk(oe_cyc == EXP_ACC && we_bad == 0, "R8 access window", oe_cyc, EXP_ACC);
        chk(rsp_cnt == 1, "R9 single response pulse", rsp_cnt, 1);
        chk(got == expect_mem[a], "R10 read data", int'(got), int'(expect_mem[a]));
    endtask

    initial begin
        #(TB_CLK_NS * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin sram[i] = 4'h0; expect_mem[i] = 4'h0; end
        t_reset();
        t_write(8'h00, 4'h5);
        t_write(8'hFF, 4'hA);
        t_write(8'h3C, 4'h9);
        t_read(8'h00);
        t_read(8'hFF);
        t_read(8'h3C);
        t_write(8'h3C, 4'h6);   // R10 overwrite
        t_read(8'h3C);
        t_write(8'h81, 4'hF);
        t_read(8'h81);
        t_read(8'h00);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule